// File: doc/BRIEF.md
# Configuration Shadow Capture

A transaction layer publishes its configuration registers over one time-shared bus. A 4-bit index names the register that the 32-bit word carries at that moment, and the index walks through the registers in rotation. This block keeps a local shadow of every register it sees, so application logic can read stable copies at any time. Each shadow changes only when its own index comes round again.

The producer flags each new word by toggling a strobe that may come from another clock domain. The block passes the strobe through a synchronizer chain, detects a change in either direction, and samples the index and word one cycle later. On top of the raw shadows it decodes the MSI control byte and offers a lookup port that maps a traffic class to its virtual channel. A parameter picks the root-port variant, which adds the bridge-only registers. In the endpoint variant those shadows are tied to zero.

Top module: `cfg_shadow_capture`

## Requirements
- R1: After reset every shadow and every valid flag is zero, `msi_vec_cnt` reads 1 and `vc_out` reads 0.
- R2: A capture starts on any change of level of `cfg_strobe`, in either direction. The new shadow value is still absent after the third rising clock edge that follows the change, and is present after the fourth. Changes of `cfg_idx` or `cfg_word` without a strobe change leave every shadow as it was.
- R3: At index 2 the one word updates two shadows: `link_ctl` takes bits [31:16] and `link_ctl2` takes bits [15:0].
- R4: The traffic-class map captured at index 8 holds eight 3-bit fields, with class t in bits [3t+2:3t]. `vc_out` returns the field chosen by `tc_sel`, except that class 0 always returns 0.
- R5: At index 7, bits [15:0] are the MSI control word and bits [31:16] are the MSI data. `msi_en` is control bit 0 and `msi_64b` is control bit 7. `msi_ctl` repeats control bits [7:0] and reads 0 in bits [15:8], so the per-vector mask bit 8 is always 0.
- R6: The vector-enable field, control bits [6:4], gives `msi_vec_cnt` = 2^code for codes 0 to 5. Codes 6 and 7 set `msi_mme_bad` and force the count to 1.
- R7: With ROOT_PORT=0, the slot, root control, bus number, I/O window, memory window and prefetchable window shadows stay zero, and their indices never set a valid flag.
- R8: Bit n of `shadow_valid` is set by the first capture at index n and then stays set until reset.
- R9: A capture at index 15 changes no shadow and no valid flag.
- R10: The MSI address takes its low 32 bits from index 5 and its high 32 bits from index 6. `msi_addr_valid` rises only once both halves have been captured since reset.
- R11: A later capture at an index overwrites the earlier value of its shadows.
- R12: Index map (word bits in brackets): 0 = device control [31:16] and device control 2 [15:0]; 1 = slot [15:0]; 3 = command [15:0] and root control [23:16]; 4 = secondary bus [7:0] and subordinate bus [15:8]; 9 = I/O base [19:0]; 10 = I/O limit [19:0]; 11 = memory base [11:0] and memory limit [27:16]; 12 = prefetchable base bits 43:32 in [11:0] and prefetchable limit bits 43:32 in [27:16]; 13 = prefetchable base [31:0]; 14 = prefetchable limit [31:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_idx | input | 4 | Index of the register currently on the shared bus |
| cfg_word | input | 32 | Shared register data word |
| cfg_strobe | input | 1 | Toggle strobe that marks a new word; may be asynchronous |
| tc_sel | input | 3 | Traffic class to look up |
| dev_ctl | output | 16 | Device control shadow |
| dev_ctl2 | output | 16 | Device control 2 shadow |
| cmd_reg | output | 16 | Command register shadow |
| link_ctl | output | 16 | Primary link control shadow |
| link_ctl2 | output | 16 | Secondary link control shadow |
| slot_ctl | output | 16 | Slot shadow (root port only) |
| root_ctl | output | 8 | Root control shadow (root port only) |
| sec_bus | output | 8 | Secondary bus number (root port only) |
| sub_bus | output | 8 | Subordinate bus number (root port only) |
| io_base | output | 20 | I/O base (root port only) |
| io_lim | output | 20 | I/O limit (root port only) |
| mem_base | output | 12 | Memory window base (root port only) |
| mem_lim | output | 12 | Memory window limit (root port only) |
| pf_base | output | 44 | Prefetchable base (root port only) |
| pf_lim | output | 44 | Prefetchable limit (root port only) |
| msi_addr | output | 64 | MSI message address |
| msi_addr_valid | output | 1 | Both address halves captured |
| msi_data | output | 16 | MSI message data |
| msi_ctl | output | 16 | Cleaned MSI control word |
| msi_en | output | 1 | MSI enabled |
| msi_64b | output | 1 | 64-bit address capable |
| msi_vec_cnt | output | 6 | Number of allocated vectors |
| msi_mme_bad | output | 1 | Reserved vector-enable code seen |
| vc_out | output | 3 | Virtual channel for `tc_sel` |
| shadow_valid | output | 16 | Per-index captured flags |

## Verification
The bench samples one capture just before and just after its update edge. A synchronizer one stage too short or too long shows up as an early or late shadow. It toggles the strobe in both directions, and it moves index and data without any toggle: a design that detects only one edge, or that captures level-sensitively, would miss updates or take the wrong word. It drives the reserved vector codes and writes a nonzero class-0 map field, where a missing clamp gives a count other than 1 or a nonzero channel. It also sends words to the spare index and to bridge-only indices on an endpoint build, where a leaky decode would corrupt shadows or set valid flags. Finally, it checks that the combined address valid waits for the second half.

// File: rtl/cfgsh_pkg.sv
package cfgsh_pkg;
    localparam int IDX_W   = 4;
    localparam int WORD_W  = 32;
    localparam int NUM_IDX = 1 << IDX_W;
    localparam int TC_W    = 3;
    localparam int NUM_TC  = 1 << TC_W;
    localparam int MAP_W   = TC_W * NUM_TC;
    localparam int MME_W   = 3;
    localparam int MAX_MME = 5;
    localparam int CNT_W   = MAX_MME + 1;

    typedef enum logic [IDX_W-1:0] {
        IX_DEVCTL  = 4'd0,
        IX_SLOT    = 4'd1,
        IX_LINK    = 4'd2,
        IX_CMDROOT = 4'd3,
        IX_BUSNUM  = 4'd4,
        IX_MSIA_LO = 4'd5,
        IX_MSIA_HI = 4'd6,
        IX_MSICTL  = 4'd7,
        IX_TCVC    = 4'd8,
        IX_IOBASE  = 4'd9,
        IX_IOLIM   = 4'd10,
        IX_MEMWIN  = 4'd11,
        IX_PFUPPER = 4'd12,
        IX_PFBASE  = 4'd13,
        IX_PFLIM   = 4'd14,
        IX_SPARE   = 4'd15
    } cfg_idx_e;

    typedef struct packed {
        logic [IDX_W-1:0]  idx;
        logic [WORD_W-1:0] word;
    } cap_beat_t;

    typedef struct packed {
        logic             en;
        logic             addr64;
        logic             mme_bad;
        logic [CNT_W-1:0] vec_cnt;
    } msi_info_t;

    function automatic logic idx_mapped(input logic [IDX_W-1:0] ix);
        return ix != IX_SPARE;
    endfunction

    function automatic logic idx_rp_only(input logic [IDX_W-1:0] ix);
        case (ix)
            IX_SLOT, IX_BUSNUM, IX_IOBASE, IX_IOLIM,
            IX_MEMWIN, IX_PFUPPER, IX_PFBASE, IX_PFLIM: return 1'b1;
            default:                                     return 1'b0;
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] mme_count(input logic [MME_W-1:0] code);
        if (int'(code) > MAX_MME) return CNT_W'(1);
        return CNT_W'(1) << code;
    endfunction
endpackage

// File: rtl/cfgsh_strobe_sync.sv
module cfgsh_strobe_sync
    import cfgsh_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe_in,
    input  logic [IDX_W-1:0]  idx_in,
    input  logic [WORD_W-1:0] word_in,
    output logic              cap_vld,
    output cap_beat_t         beat
);
    // chain[0..STAGES-1] synchronize, chain[STAGES] holds the previous level
    logic [STAGES:0] chain_q;
    logic            edge_seen;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-1:0], strobe_in};
    end

    assign edge_seen = chain_q[STAGES] ^ chain_q[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_vld <= 1'b0;
            beat    <= '0;
        end else begin
            cap_vld <= edge_seen;
            if (edge_seen) begin
                beat.idx  <= idx_in;
                beat.word <= word_in;
            end
        end
    end
endmodule

// File: rtl/cfgsh_msi_decode.sv
module cfgsh_msi_decode
    import cfgsh_pkg::*;
(
    input  logic [7:0]  ctl_lo,
    output msi_info_t   info,
    output logic [15:0] ctl_clean
);
    logic [MME_W-1:0] mme_code;

    assign mme_code       = ctl_lo[6:4];
    assign info.en        = ctl_lo[0];
    assign info.addr64    = ctl_lo[7];
    assign info.mme_bad   = int'(mme_code) > MAX_MME;
    assign info.vec_cnt   = mme_count(mme_code);
    assign ctl_clean      = {8'h00, ctl_lo};
endmodule

// File: rtl/cfgsh_tcvc_lookup.sv
module cfgsh_tcvc_lookup
    import cfgsh_pkg::*;
(
    input  logic [MAP_W-1:0] tc_map,
    input  logic [TC_W-1:0]  tc_sel,
    output logic [TC_W-1:0]  vc
);
    logic [TC_W-1:0] fld [NUM_TC];

    for (genvar t = 0; t < NUM_TC; t++) begin : g_fld
        assign fld[t] = tc_map[t*TC_W +: TC_W];
    end

    assign vc = (tc_sel == '0) ? '0 : fld[tc_sel];
endmodule

// File: rtl/cfg_shadow_capture.sv
module cfg_shadow_capture
    import cfgsh_pkg::*;
#(
    parameter bit ROOT_PORT   = 1'b1,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [WORD_W-1:0] cfg_word,
    input  logic              cfg_strobe,
    input  logic [TC_W-1:0]   tc_sel,
    output logic [15:0]       dev_ctl,
    output logic [15:0]       dev_ctl2,
    output logic [15:0]       cmd_reg,
    output logic [15:0]       link_ctl,
    output logic [15:0]       link_ctl2,
    output logic [15:0]       slot_ctl,
    output logic [7:0]        root_ctl,
    output logic [7:0]        sec_bus,
    output logic [7:0]        sub_bus,
    output logic [19:0]       io_base,
    output logic [19:0]       io_lim,
    output logic [11:0]       mem_base,
    output logic [11:0]       mem_lim,
    output logic [43:0]       pf_base,
    output logic [43:0]       pf_lim,
    output logic [63:0]       msi_addr,
    output logic              msi_addr_valid,
    output logic [15:0]       msi_data,
    output logic [15:0]       msi_ctl,
    output logic              msi_en,
    output logic              msi_64b,
    output logic [CNT_W-1:0]  msi_vec_cnt,
    output logic              msi_mme_bad,
    output logic [TC_W-1:0]   vc_out,
    output logic [NUM_IDX-1:0] shadow_valid
);
    logic              cap_vld;
    cap_beat_t         beat;
    logic [IDX_W-1:0]  ix;
    logic [WORD_W-1:0] w;
    logic              take;
    logic [7:0]        msi_ctl_q;
    logic [MAP_W-1:0]  tc_map_q;
    logic [NUM_IDX-1:0] valid_q;
    msi_info_t         msi_info;

    cfgsh_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .strobe_in (cfg_strobe),
        .idx_in    (cfg_idx),
        .word_in   (cfg_word),
        .cap_vld   (cap_vld),
        .beat      (beat)
    );

    assign ix   = beat.idx;
    assign w    = beat.word;
    assign take = cap_vld && idx_mapped(ix) && (ROOT_PORT || !idx_rp_only(ix));

    // shadows present in both variants
    always_ff @(posedge clk) begin
        if (rst) begin
            dev_ctl   <= '0;
            dev_ctl2  <= '0;
            cmd_reg   <= '0;
            link_ctl  <= '0;
            link_ctl2 <= '0;
            msi_addr  <= '0;
            msi_data  <= '0;
            msi_ctl_q <= '0;
            tc_map_q  <= '0;
        end else if (take) begin
            case (cfg_idx_e'(ix))
                IX_DEVCTL: begin
                    dev_ctl  <= w[31:16];
                    dev_ctl2 <= w[15:0];
                end
                IX_LINK: begin
                    link_ctl  <= w[31:16];
                    link_ctl2 <= w[15:0];
                end
                IX_CMDROOT: cmd_reg        <= w[15:0];
                IX_MSIA_LO: msi_addr[31:0]  <= w;
                IX_MSIA_HI: msi_addr[63:32] <= w;
                IX_MSICTL: begin
                    msi_ctl_q <= w[7:0];
                    msi_data  <= w[31:16];
                end
                IX_TCVC:   tc_map_q <= w[MAP_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)       valid_q <= '0;
        else if (take) valid_q[ix] <= 1'b1;
    end

    assign shadow_valid   = valid_q;
    assign msi_addr_valid = valid_q[IX_MSIA_LO] && valid_q[IX_MSIA_HI];

    // bridge-only shadows
    if (ROOT_PORT) begin : g_rp
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_ctl <= '0;
                root_ctl <= '0;
                sec_bus  <= '0;
                sub_bus  <= '0;
                io_base  <= '0;
                io_lim   <= '0;
                mem_base <= '0;
                mem_lim  <= '0;
                pf_base  <= '0;
                pf_lim   <= '0;
            end else if (take) begin
                case (cfg_idx_e'(ix))
                    IX_SLOT:    slot_ctl <= w[15:0];
                    IX_CMDROOT: root_ctl <= w[23:16];
                    IX_BUSNUM: begin
                        sec_bus <= w[7:0];
                        sub_bus <= w[15:8];
                    end
                    IX_IOBASE:  io_base <= w[19:0];
                    IX_IOLIM:   io_lim  <= w[19:0];
                    IX_MEMWIN: begin
                        mem_base <= w[11:0];
                        mem_lim  <= w[27:16];
                    end
                    IX_PFUPPER: begin
                        pf_base[43:32] <= w[11:0];
                        pf_lim[43:32]  <= w[27:16];
                    end
                    IX_PFBASE:  pf_base[31:0] <= w;
                    IX_PFLIM:   pf_lim[31:0]  <= w;
                    default: ;
                endcase
            end
        end
    end else begin : g_ep
        assign slot_ctl = '0;
        assign root_ctl = '0;
        assign sec_bus  = '0;
        assign sub_bus  = '0;
        assign io_base  = '0;
        assign io_lim   = '0;
        assign mem_base = '0;
        assign mem_lim  = '0;
        assign pf_base  = '0;
        assign pf_lim   = '0;
    end

    cfgsh_msi_decode u_msi (
        .ctl_lo    (msi_ctl_q),
        .info      (msi_info),
        .ctl_clean (msi_ctl)
    );

    assign msi_en      = msi_info.en;
    assign msi_64b     = msi_info.addr64;
    assign msi_mme_bad = msi_info.mme_bad;
    assign msi_vec_cnt = msi_info.vec_cnt;

    cfgsh_tcvc_lookup u_tcvc (
        .tc_map (tc_map_q),
        .tc_sel (tc_sel),
        .vc     (vc_out)
    );

    // R3
    link_split_chk: assert property (@(posedge clk) disable iff (rst)
        (cap_vld && beat.idx == IX_LINK) |=>
            (link_ctl == $past(beat.word[31:16]) && link_ctl2 == $past(beat.word[15:0])));

    // R9
    spare_idx_chk: assert property (@(posedge clk) disable iff (rst)
        (cap_vld && beat.idx == IX_SPARE) |=>
            ($stable(valid_q) && $stable(dev_ctl) && $stable(link_ctl) && $stable(msi_addr)));

    // R8
    valid_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cap_vld |=> $stable(shadow_valid));

    // R10
    addr_pair_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(msi_addr_valid) |-> $past(cap_vld));

    // R4
    tc0_chk: assert property (@(posedge clk) disable iff (rst)
        (tc_sel == '0) |-> (vc_out == '0));

    // R6
    vec_cnt_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(msi_vec_cnt) == 1 && (!msi_mme_bad || msi_vec_cnt == CNT_W'(1)));
endmodule

// File: tb/tb_cfg_shadow_capture.sv
module tb_cfg_shadow_capture;
    import cfgsh_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [3:0]  cfg_idx = '0;
    logic [31:0] cfg_word = '0;
    logic        cfg_strobe = 1'b0;
    logic [2:0]  tc_sel = '0;

    always #4 clk = ~clk;

    logic [15:0] dev_ctl, dev_ctl2, cmd_reg, link_ctl, link_ctl2, slot_ctl, msi_data, msi_ctl;
    logic [7:0]  root_ctl, sec_bus, sub_bus;
    logic [19:0] io_base, io_lim;
    logic [11:0] mem_base, mem_lim;
    logic [43:0] pf_base, pf_lim;
    logic [63:0] msi_addr;
    logic        msi_addr_valid, msi_en, msi_64b, msi_mme_bad;
    logic [5:0]  msi_vec_cnt;
    logic [2:0]  vc_out;
    logic [15:0] shadow_valid;

    logic [15:0] e_dev_ctl, e_dev_ctl2, e_cmd_reg, e_link_ctl, e_link_ctl2, e_slot_ctl, e_msi_data, e_msi_ctl;
    logic [7:0]  e_root_ctl, e_sec_bus, e_sub_bus;
    logic [19:0] e_io_base, e_io_lim;
    logic [11:0] e_mem_base, e_mem_lim;
    logic [43:0] e_pf_base, e_pf_lim;
    logic [63:0] e_msi_addr;
    logic        e_msi_addr_valid, e_msi_en, e_msi_64b, e_msi_mme_bad;
    logic [5:0]  e_msi_vec_cnt;
    logic [2:0]  e_vc_out;
    logic [15:0] e_shadow_valid;

    cfg_shadow_capture #(.ROOT_PORT(1'b1)) dut (
        .clk(clk), .rst(rst), .cfg_idx(cfg_idx), .cfg_word(cfg_word), .cfg_strobe(cfg_strobe),
        .tc_sel(tc_sel), .dev_ctl(dev_ctl), .dev_ctl2(dev_ctl2), .cmd_reg(cmd_reg),
        .link_ctl(link_ctl), .link_ctl2(link_ctl2), .slot_ctl(slot_ctl), .root_ctl(root_ctl),
        .sec_bus(sec_bus), .sub_bus(sub_bus), .io_base(io_base), .io_lim(io_lim),
        .mem_base(mem_base), .mem_lim(mem_lim), .pf_base(pf_base), .pf_lim(pf_lim),
        .msi_addr(msi_addr), .msi_addr_valid(msi_addr_valid), .msi_data(msi_data),
        .msi_ctl(msi_ctl), .msi_en(msi_en), .msi_64b(msi_64b), .msi_vec_cnt(msi_vec_cnt),
        .msi_mme_bad(msi_mme_bad), .vc_out(vc_out), .shadow_valid(shadow_valid)
    );

    cfg_shadow_capture #(.ROOT_PORT(1'b0)) dut_ep (
        .clk(clk), .rst(rst), .cfg_idx(cfg_idx), .cfg_word(cfg_word), .cfg_strobe(cfg_strobe),
        .tc_sel(tc_sel), .dev_ctl(e_dev_ctl), .dev_ctl2(e_dev_ctl2), .cmd_reg(e_cmd_reg),
        .link_ctl(e_link_ctl), .link_ctl2(e_link_ctl2), .slot_ctl(e_slot_ctl), .root_ctl(e_root_ctl),
        .sec_bus(e_sec_bus), .sub_bus(e_sub_bus), .io_base(e_io_base), .io_lim(e_io_lim),
        .mem_base(e_mem_base), .mem_lim(e_mem_lim), .pf_base(e_pf_base), .pf_lim(e_pf_lim),
        .msi_addr(e_msi_addr), .msi_addr_valid(e_msi_addr_valid), .msi_data(e_msi_data),
        .msi_ctl(e_msi_ctl), .msi_en(e_msi_en), .msi_64b(e_msi_64b), .msi_vec_cnt(e_msi_vec_cnt),
        .msi_mme_bad(e_msi_mme_bad), .vc_out(e_vc_out), .shadow_valid(e_shadow_valid)
    );

    int total = 0;
    int bad   = 0;
    bit ended = 1'b0;

    typedef struct {
        int          sel;
        logic [63:0] exp;
        string       req;
    } sb_item_t;
    sb_item_t sb_q[$];

    function automatic logic [63:0] port_val(input int sel);
        case (sel)
            0:  return 64'(dev_ctl);
            1:  return 64'(dev_ctl2);
            2:  return 64'(link_ctl);
            3:  return 64'(link_ctl2);
            4:  return 64'(vc_out);
            5:  return 64'(msi_ctl);
            6:  return 64'(msi_data);
            7:  return 64'(msi_en);
            8:  return 64'(msi_64b);
            9:  return 64'(msi_vec_cnt);
            10: return 64'(msi_mme_bad);
            11: return msi_addr;
            12: return 64'(msi_addr_valid);
            13: return 64'(shadow_valid);
            14: return 64'(sec_bus);
            15: return 64'(sub_bus);
            16: return 64'(e_sec_bus);
            17: return 64'(e_shadow_valid);
            18: return 64'(io_base);
            19: return pf_base;
            20: return 64'(e_pf_base);
            21: return 64'(cmd_reg);
            22: return 64'(root_ctl);
            23: return 64'(e_root_ctl);
            24: return 64'(e_io_base);
            default: return '0;
        endcase
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic expect_v(input int sel, input logic [63:0] exp, input string req);
        sb_item_t it;
        it.sel = sel;
        it.exp = exp;
        it.req = req;
        sb_q.push_back(it);
    endtask

    task automatic drain();
        while (sb_q.size() > 0) @(negedge clk);
        @(negedge clk);
    endtask

    // monitor: pops expected items and compares against the ports
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            sb_item_t it;
            it = sb_q.pop_front();
            chk(it.req, port_val(it.sel), it.exp);
        end
    end

    task automatic wr(input logic [3:0] ix, input logic [31:0] d);
        @(negedge clk);
        cfg_idx    = ix;
        cfg_word   = d;
        cfg_strobe = ~cfg_strobe;
        repeat (6) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    logic [23:0] tmap;

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        expect_v(0, 64'h0, "R1 dev_ctl");
        expect_v(13, 64'h0, "R1 shadow_valid");
        expect_v(9, 64'd1, "R1 msi_vec_cnt");
        expect_v(4, 64'h0, "R1 vc_out");
        expect_v(11, 64'h0, "R1 msi_addr");
        drain();

        // R2 exact latency, rising strobe
        @(negedge clk);
        cfg_idx = 4'd0; cfg_word = 32'hA5A5_1234; cfg_strobe = 1'b1;
        repeat (3) @(negedge clk);
        chk("R2 before 4th edge", 64'(dev_ctl), 64'h0);
        @(negedge clk);
        chk("R2 after 4th edge", 64'(dev_ctl), 64'hA5A5);
        chk("R12 dev_ctl2 low half", 64'(dev_ctl2), 64'h1234);
        repeat (3) @(negedge clk);

        // R2 no strobe change: nothing captured
        cfg_word = 32'h1111_2222;
        repeat (8) @(negedge clk);
        expect_v(0, 64'hA5A5, "R2 no toggle dev_ctl");
        expect_v(1, 64'h1234, "R2 no toggle dev_ctl2");
        // R8 valid flags
        expect_v(13, 64'h0001, "R8 valid after idx0");
        drain();

        // R2 falling strobe also captures; R3 link split
        wr(4'd2, 32'h0020_0003);
        expect_v(2, 64'h0020, "R3 link_ctl");
        expect_v(3, 64'h0003, "R3 link_ctl2");
        expect_v(13, 64'h0005, "R8 valid idx0 idx2");
        drain();

        // R11 overwrite
        wr(4'd2, 32'h1234_8765);
        expect_v(2, 64'h1234, "R11 link_ctl overwrite");
        expect_v(3, 64'h8765, "R11 link_ctl2 overwrite");
        drain();

        // R4 traffic-class lookup, class 0 field nonzero
        for (int t = 0; t < 8; t++) tmap[t*3 +: 3] = 3'(t) ^ 3'b101;
        wr(4'd8, {8'h00, tmap});
        for (int t = 0; t < 8; t++) begin
            @(negedge clk);
            tc_sel = 3'(t);
            expect_v(4, (t == 0) ? 64'h0 : 64'(3'(t) ^ 3'b101), "R4 vc lookup");
            drain();
        end

        // R5 MSI control decode, R6 count 8
        wr(4'd7, 32'hBEEF_01B1);
        expect_v(5, 64'h00B1, "R5 msi_ctl bit8 cleared");
        expect_v(6, 64'hBEEF, "R5 msi_data");
        expect_v(7, 64'd1, "R5 msi_en");
        expect_v(8, 64'd1, "R5 msi_64b");
        expect_v(9, 64'd8, "R6 cnt code 3");
        expect_v(10, 64'd0, "R6 not reserved");
        drain();

        wr(4'd7, 32'h0000_0050);
        expect_v(9, 64'd32, "R6 cnt code 5");
        expect_v(7, 64'd0, "R5 msi_en off");
        drain();
        wr(4'd7, 32'h0000_0060);
        expect_v(9, 64'd1, "R6 code 6 count");
        expect_v(10, 64'd1, "R6 code 6 flag");
        drain();
        wr(4'd7, 32'h0000_0070);
        expect_v(9, 64'd1, "R6 code 7 count");
        expect_v(10, 64'd1, "R6 code 7 flag");
        drain();
        wr(4'd7, 32'h0000_0000);
        expect_v(9, 64'd1, "R6 code 0 count");
        expect_v(10, 64'd0, "R6 code 0 flag");
        drain();

        // R10 two-part address
        wr(4'd5, 32'hDEAD_BEEF);
        expect_v(12, 64'd0, "R10 only low half");
        expect_v(11, 64'h0000_0000_DEAD_BEEF, "R10 low half");
        drain();
        wr(4'd6, 32'h0000_00FE);
        expect_v(12, 64'd1, "R10 both halves");
        expect_v(11, 64'h0000_00FE_DEAD_BEEF, "R10 full address");
        drain();

        // R9 spare index ignored
        wr(4'd15, 32'hFFFF_FFFF);
        expect_v(13, 64'h01E5, "R9 valid unchanged");
        expect_v(2, 64'h1234, "R9 link_ctl unchanged");
        expect_v(0, 64'hA5A5, "R9 dev_ctl unchanged");
        expect_v(11, 64'h0000_00FE_DEAD_BEEF, "R9 msi_addr unchanged");
        drain();

        // R7 / R12 bridge-only registers
        wr(4'd4, 32'h0000_0302);
        expect_v(14, 64'h02, "R12 sec_bus");
        expect_v(15, 64'h03, "R12 sub_bus");
        expect_v(16, 64'h00, "R7 endpoint sec_bus");
        drain();
        wr(4'd3, 32'h00C4_0406);
        expect_v(21, 64'h0406, "R12 cmd_reg");
        expect_v(22, 64'hC4, "R12 root_ctl");
        expect_v(23, 64'h00, "R7 endpoint root_ctl");
        drain();
        wr(4'd9, 32'h000A_BCDE);
        expect_v(18, 64'hABCDE, "R12 io_base");
        expect_v(24, 64'h0, "R7 endpoint io_base");
        drain();
        wr(4'd13, 32'h8000_0000);
        wr(4'd12, 32'h0BBB_0AAA);
        expect_v(19, 64'h0AAA_8000_0000, "R12 pf_base");
        expect_v(20, 64'h0, "R7 endpoint pf_base");
        expect_v(17, 64'h01ED, "R7 endpoint valid flags");
        drain();

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule